// File: doc/BRIEF.md
# Wavefront Register Admission Allocator

This block decides whether a new wavefront can start on one of the SIMD units of a compute unit. Each SIMD owns a vector register file whose registers are statically divided among the waves that live on it. A wave of 64 lanes that asks for N registers per lane holds N x 64 registers for as long as it lives. A SIMD also has a fixed number of wave slots. All SIMDs share one pool of scalar registers, tracked as a single counter. A request is admitted only if some SIMD has a free slot and a contiguous free register range of the right size, and the scalar pool can also cover it.

The register file is handled in granules of 64 registers, so a wave asking for N registers per lane takes exactly N granules. Placement is first-fit: the lowest SIMD that can take the wave wins. Inside that SIMD the wave gets the lowest free slot and the lowest-addressed free range. The grant (SIMD, slot, base register address) is presented in the same cycle as the request. When a wave finishes, a completion pulse returns its slot, its register range and its scalar registers. A completion in the same cycle as a request is applied first, so the request can already use what was freed.

Requests use a valid/ready handshake. `req_ready` is computed from the request fields and the current state. It does not depend on `req_valid`. A request is accepted on a rising edge where both signals are high. A stalled requester must hold `req_vregs` and `req_sregs` stable until it is accepted. The grant outputs are meaningful whenever `req_ready` is high. Completions have no back-pressure.

Top module: `wave_reg_admit`

## Requirements
- R1: Each SIMD has 16384 vector registers, split into 256 granules of 64. A wave asking for N registers per lane occupies N x 64 contiguous registers. Its base address (`gnt_base`) is a multiple of 64, and the range ends inside the file.
- R2: Within the chosen SIMD, the base is the lowest granule-aligned address at which N granules in a row are all free.
- R3: The granted SIMD (`gnt_simd`) is the lowest-numbered SIMD that has both a free slot and a fitting register range.
- R4: The granted slot (`gnt_slot`, 0 to 9) is the lowest free slot of that SIMD. A SIMD never holds more than 10 waves, even when registers remain free.
- R5: `req_ready` is low when no SIMD can take the request. For example, with 84 registers per lane, three waves fit in a SIMD (16128 registers), and a fourth is refused on that SIMD.
- R6: One scalar pool of 512 registers is shared by all SIMDs. A request is refused while `req_sregs` exceeds the scalar registers still free.
- R7: A completion (`done_valid` with `done_simd`, `done_slot`) returns that wave's slot, register range and scalar registers. A completion naming an idle or nonexistent slot changes nothing.
- R8: When a completion and a request arrive in the same cycle, the completion is applied first, and the request may use the freed resources.
- R9: A request with `req_vregs` of 0 or greater than 256 is never ready.
- R10: After reset, all slots, registers and scalar registers are free. The grant appears combinationally, in the same cycle as the acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Admission request present |
| req_ready | output | 1 | Request can be admitted this cycle |
| req_vregs | input | 9 | Vector registers per lane (legal range 1 to 256) |
| req_sregs | input | 10 | Scalar registers the wave needs |
| gnt_simd | output | 2 | SIMD chosen for the wave |
| gnt_slot | output | 4 | Wave slot chosen within that SIMD |
| gnt_base | output | 14 | Base vector register address of the wave's range |
| done_valid | input | 1 | A wave has completed |
| done_simd | input | 2 | SIMD of the completed wave |
| done_slot | input | 4 | Slot of the completed wave |

## Verification
The hardest case to reach is fragmentation. A SIMD can have enough free registers in total, but no free run long enough, so first-fit has to skip holes or move on to a later SIMD. Directed cases cannot easily build that state from the ports. The random phase gets there by churn: it mixes requests of varied sizes with completions of random slots over thousands of cycles, and a bench model predicts every grant. Directed cases cover the 84-register example, the slot cap, scalar exhaustion, illegal sizes and a completion that coincides with a request on a full unit.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int unsigned WAVE_LANES = 64;
  localparam int unsigned DEF_SIMDS  = 4;
  localparam int unsigned DEF_VREGS  = 16384;
  localparam int unsigned DEF_SLOTS  = 10;
  localparam int unsigned DEF_SREGS  = 512;
endpackage

// File: rtl/wa_first_fit.sv
module wa_first_fit #(
  parameter int GRANS = 256,
  parameter int CW    = 9,
  parameter int GW    = 8
) (
  input  logic [GRANS-1:0] free_map,
  input  logic [CW-1:0]    need,
  output logic             found,
  output logic [GW-1:0]    start
);
  // Running length of free granules; the first end that reaches need gives the lowest start
  always_comb begin
    int run;
    run   = 0;
    found = 1'b0;
    start = '0;
    for (int i = 0; i < GRANS; i++) begin
      run = free_map[i] ? run + 1 : 0;
      if (!found && need != '0 && run >= int'(need)) begin
        found = 1'b1;
        start = GW'(i + 1 - int'(need));
      end
    end
  end
endmodule

// File: rtl/wa_span_mask.sv
module wa_span_mask #(
  parameter int GRANS = 256,
  parameter int CW    = 9,
  parameter int GW    = 8
) (
  input  logic [GW-1:0]    base,
  input  logic [CW-1:0]    len,
  output logic [GRANS-1:0] mask
);
  always_comb begin
    for (int i = 0; i < GRANS; i++)
      mask[i] = (i >= int'(base)) && (i < int'(base) + int'(len));
  end
endmodule

// File: rtl/wa_simd_bank.sv
module wa_simd_bank #(
  parameter int GRANS = 256,
  parameter int SLOTS = 10,
  parameter int CW    = 9,
  parameter int GW    = 8,
  parameter int SLW   = 4,
  parameter int SRW   = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  need,
  input  logic [SRW-1:0] alloc_sregs,
  input  logic           alloc_en,
  input  logic           free_en,
  input  logic [SLW-1:0] free_slot,
  output logic           fits,
  output logic [GW-1:0]  fit_base,
  output logic [SLW-1:0] fit_slot,
  output logic [SRW-1:0] freed_sregs
);
  logic [GRANS-1:0] used_q, used_now, rel_mask, take_mask;
  logic [SLOTS-1:0] busy_q, busy_now;
  logic [GW-1:0]    base_q [SLOTS];
  logic [CW-1:0]    len_q  [SLOTS];
  logic [SRW-1:0]   sreg_q [SLOTS];
  logic [GW-1:0]    rel_base;
  logic [CW-1:0]    rel_len;
  logic             range_ok, slot_ok;

  // Release decode: only a busy, in-range slot frees anything
  always_comb begin
    rel_base    = '0;
    rel_len     = '0;
    freed_sregs = '0;
    busy_now    = busy_q;
    for (int k = 0; k < SLOTS; k++) begin
      if (free_en && SLW'(k) == free_slot && busy_q[k]) begin
        rel_base    = base_q[k];
        rel_len     = len_q[k];
        freed_sregs = sreg_q[k];
        busy_now[k] = 1'b0;
      end
    end
  end

  wa_span_mask #(.GRANS(GRANS), .CW(CW), .GW(GW)) u_rel_mask (
    .base(rel_base), .len(rel_len), .mask(rel_mask));

  assign used_now = used_q & ~rel_mask;

  wa_first_fit #(.GRANS(GRANS), .CW(CW), .GW(GW)) u_fit (
    .free_map(~used_now), .need(need), .found(range_ok), .start(fit_base));

  always_comb begin
    slot_ok  = 1'b0;
    fit_slot = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!slot_ok && !busy_now[k]) begin
        slot_ok  = 1'b1;
        fit_slot = SLW'(k);
      end
    end
  end

  assign fits = range_ok && slot_ok;

  wa_span_mask #(.GRANS(GRANS), .CW(CW), .GW(GW)) u_take_mask (
    .base(fit_base), .len(need), .mask(take_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      busy_q <= '0;
      for (int k = 0; k < SLOTS; k++) begin
        base_q[k] <= '0;
        len_q[k]  <= '0;
        sreg_q[k] <= '0;
      end
    end else begin
      used_q <= used_now | (alloc_en ? take_mask : '0);
      busy_q <= busy_now;
      if (alloc_en) begin
        busy_q[fit_slot] <= 1'b1;
        base_q[fit_slot] <= fit_base;
        len_q[fit_slot]  <= need;
        sreg_q[fit_slot] <= alloc_sregs;
      end
    end
  end

  // An enable from the top must land on space that is free after this cycle's release
  p_alloc_space_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (fits && ((used_now & take_mask) == '0)));

  // A wave slot is only released by a completion addressed to this bank
  p_release_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !free_en |=> ((busy_q & $past(busy_q)) == $past(busy_q)));
endmodule

// File: rtl/wave_reg_admit.sv
module wave_reg_admit
  import wa_pkg::*;
#(
  parameter int NUM_SIMD       = DEF_SIMDS,
  parameter int VREGS_PER_SIMD = DEF_VREGS,
  parameter int WAVE_SLOTS     = DEF_SLOTS,
  parameter int SREG_POOL      = DEF_SREGS,
  localparam int GRANS = VREGS_PER_SIMD / WAVE_LANES,
  localparam int CW    = $clog2(GRANS + 1),
  localparam int GW    = $clog2(GRANS),
  localparam int LW    = $clog2(WAVE_LANES),
  localparam int AW    = GW + LW,
  localparam int SLW   = $clog2(WAVE_SLOTS),
  localparam int SIW   = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int SRW   = $clog2(SREG_POOL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [CW-1:0]  req_vregs,
  input  logic [SRW-1:0] req_sregs,
  output logic [SIW-1:0] gnt_simd,
  output logic [SLW-1:0] gnt_slot,
  output logic [AW-1:0]  gnt_base,
  input  logic           done_valid,
  input  logic [SIW-1:0] done_simd,
  input  logic [SLW-1:0] done_slot
);
  logic [NUM_SIMD-1:0] fit_v, alloc_v;
  logic [GW-1:0]       base_v  [NUM_SIMD];
  logic [SLW-1:0]      slot_v  [NUM_SIMD];
  logic [SRW-1:0]      fsreg_v [NUM_SIMD];
  logic [SRW-1:0]      sfree_q, sfree_now;
  logic                any_fit, accept;

  for (genvar g = 0; g < NUM_SIMD; g++) begin : g_bank
    wa_simd_bank #(.GRANS(GRANS), .SLOTS(WAVE_SLOTS), .CW(CW), .GW(GW),
                   .SLW(SLW), .SRW(SRW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .need(req_vregs), .alloc_sregs(req_sregs), .alloc_en(alloc_v[g]),
      .free_en(done_valid && done_simd == SIW'(g)), .free_slot(done_slot),
      .fits(fit_v[g]), .fit_base(base_v[g]), .fit_slot(slot_v[g]),
      .freed_sregs(fsreg_v[g]));
  end

  // Scalar returns from a completion count this cycle; lowest fitting SIMD wins
  always_comb begin
    sfree_now = sfree_q;
    for (int g = 0; g < NUM_SIMD; g++) sfree_now = sfree_now + fsreg_v[g];
    any_fit  = 1'b0;
    gnt_simd = '0;
    for (int g = 0; g < NUM_SIMD; g++) begin
      if (!any_fit && fit_v[g]) begin
        any_fit  = 1'b1;
        gnt_simd = SIW'(g);
      end
    end
  end

  assign req_ready = any_fit && (req_sregs <= sfree_now);
  assign accept    = req_valid && req_ready;
  assign gnt_slot  = slot_v[gnt_simd];
  assign gnt_base  = {base_v[gnt_simd], LW'(0)};

  always_comb begin
    alloc_v = '0;
    if (accept) alloc_v[gnt_simd] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sfree_q <= SRW'(SREG_POOL);
    else        sfree_q <= sfree_now - (accept ? req_sregs : '0);
  end

  p_sreg_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sfree_q) <= SREG_POOL);

  p_grant_in_file_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (int'(gnt_base) + int'(req_vregs) * int'(WAVE_LANES) <= VREGS_PER_SIMD));

  p_illegal_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vregs == '0 || int'(req_vregs) > GRANS) |-> !req_ready);

  p_one_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_v) && (accept == (alloc_v != '0)));
endmodule

// File: tb/wave_reg_admit_test.sv
`timescale 1ns/1ps
module wave_reg_admit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [8:0] req_vregs = '0;
  logic [9:0] req_sregs = '0;
  logic [1:0] gnt_simd;
  logic [3:0] gnt_slot;
  logic [13:0] gnt_base;
  logic       done_valid = 1'b0;
  logic [1:0] done_simd = '0;
  logic [3:0] done_slot = '0;

  int checks = 0;
  int errors = 0;

  bit m_used [4][256];
  bit m_busy [4][10];
  int m_base [4][10];
  int m_len  [4][10];
  int m_sr   [4][10];
  int m_sfree;

  always #5 clk = ~clk;

  wave_reg_admit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vregs(req_vregs), .req_sregs(req_sregs), .gnt_simd(gnt_simd),
    .gnt_slot(gnt_slot), .gnt_base(gnt_base), .done_valid(done_valid),
    .done_simd(done_simd), .done_slot(done_slot));

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < 4; s++) begin
      for (int g = 0; g < 256; g++) m_used[s][g] = 1'b0;
      for (int k = 0; k < 10; k++) m_busy[s][k] = 1'b0;
    end
    m_sfree = 512;
  endfunction

  function automatic void model_free(int sd, int sl);
    if (sd < 4 && sl < 10 && m_busy[sd][sl]) begin
      for (int g = m_base[sd][sl]; g < m_base[sd][sl] + m_len[sd][sl]; g++) m_used[sd][g] = 1'b0;
      m_busy[sd][sl] = 1'b0;
      m_sfree += m_sr[sd][sl];
    end
  endfunction

  function automatic void predict(int n, int s, output bit ok, output int ps,
                                  output int pslot, output int pbase);
    ok = 0; ps = 0; pslot = 0; pbase = 0;
    if (n < 1 || n > 256 || s > m_sfree) return;
    for (int sd = 0; sd < 4; sd++) begin
      int sl;
      sl = -1;
      for (int k = 9; k >= 0; k--) if (!m_busy[sd][k]) sl = k;
      if (sl < 0) continue;
      for (int b = 0; b + n <= 256; b++) begin
        bit clear;
        clear = 1;
        for (int j = b; j < b + n; j++) if (m_used[sd][j]) clear = 0;
        if (clear) begin
          ok = 1; ps = sd; pslot = sl; pbase = b;
          return;
        end
      end
    end
  endfunction

  task automatic cycle(bit v, int n, int s, bit dv, int dsd, int dsl, string tag);
    bit ok;
    int ps, pslot, pbase;
    @(negedge clk);
    req_valid = v; req_vregs = 9'(n); req_sregs = 10'(s);
    done_valid = dv; done_simd = 2'(dsd); done_slot = 4'(dsl);
    #1;
    if (dv) model_free(dsd, dsl);
    predict(n, s, ok, ps, pslot, pbase);
    check($sformatf("%s R5 ready n=%0d s=%0d", tag, n, s), int'(req_ready), int'(ok));
    if (ok) begin
      check($sformatf("%s R3 simd", tag), int'(gnt_simd), ps);
      check($sformatf("%s R4 slot", tag), int'(gnt_slot), pslot);
      check($sformatf("%s R1 R2 base", tag), int'(gnt_base), pbase * 64);
      if (v) begin
        for (int g = pbase; g < pbase + n; g++) m_used[ps][g] = 1'b1;
        m_busy[ps][pslot] = 1'b1;
        m_base[ps][pslot] = pbase;
        m_len[ps][pslot]  = n;
        m_sr[ps][pslot]   = s;
        m_sfree -= s;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; done_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R10: reset state, grant visible without valid
    cycle(0, 1, 0, 0, 0, 0, "R10 reset");
    check("R10 reset ready", int'(req_ready), 1);
    check("R10 reset base", int'(gnt_base), 0);

    // R5: 84 regs per lane -> three per SIMD, 13th request refused
    for (int i = 0; i < 13; i++) cycle(1, 84, 0, 0, 0, 0, "R5 84x");
    check("R5 thirteenth 84-reg wave refused", int'(req_ready), 0);

    // R8: completion and request together on a full unit
    cycle(1, 84, 0, 1, 2, 1, "R8 same-cycle");
    check("R8 freed slot reused", int'(gnt_slot), 1);
    check("R8 freed range reused", int'(gnt_base), 84 * 64);

    // R7: completions naming idle or nonexistent slots change nothing
    cycle(1, 84, 0, 1, 0, 7, "R7 idle done");
    check("R7 idle completion ignored", int'(req_ready), 0);
    cycle(1, 84, 0, 1, 1, 12, "R7 bad slot");
    check("R7 out-of-range completion ignored", int'(req_ready), 0);
    cycle(1, 84, 0, 1, 3, 0, "R7 real done");
    check("R7 returned wave reusable", int'(req_ready), 1);

    // R4: slot cap with registers left over
    do_reset();
    for (int i = 0; i < 11; i++) cycle(1, 1, 0, 0, 0, 0, "R4 cap");
    check("R4 eleventh wave moves to SIMD1", int'(gnt_simd), 1);

    // R6: scalar pool
    do_reset();
    cycle(0, 1, 513, 0, 0, 0, "R6 over");
    check("R6 oversize scalar refused", int'(req_ready), 0);
    cycle(1, 1, 512, 0, 0, 0, "R6 full");
    cycle(1, 1, 1, 0, 0, 0, "R6 empty");
    check("R6 scalar pool exhausted", int'(req_ready), 0);

    // R9: illegal sizes; R1 whole-file wave
    do_reset();
    cycle(1, 0, 0, 0, 0, 0, "R9 zero");
    check("R9 zero size refused", int'(req_ready), 0);
    cycle(1, 257, 0, 0, 0, 0, "R9 big");
    check("R9 oversize refused", int'(req_ready), 0);
    cycle(1, 256, 0, 0, 0, 0, "R1 whole");
    check("R1 whole file granted", int'(req_ready), 1);

    // Random churn: fragmentation and mixed completions
    do_reset();
    for (int i = 0; i < 2500; i++) begin
      int r, n;
      r = int'($urandom % 20);
      n = (r == 0) ? 0 : (r == 1) ? 300 : 1 + int'($urandom % 40);
      cycle(($urandom % 4) != 0, n, int'($urandom % 60),
            ($urandom % 3) == 0, int'($urandom % 4), int'($urandom % 12), "rnd");
    end

    @(negedge clk);
    req_valid = 1'b0; done_valid = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule